// File: doc/BRIEF.md
# Time-Shared Four-Input Logic Table

This block is one logic cell that does eight jobs. A table of sixteen entries is addressed by a 4-bit logic input, and every entry holds eight configuration bits, one for each context. A free-running context counter steps through the contexts on every fast clock edge in a fixed order, returning to context 0 after context 7. The output is the bit at the current address in the current context, so one table computes eight different Boolean functions inside each user-visible cycle of eight fast cycles.

The surrounding fabric uses the user-cycle strobe to mark the start of each group of eight contexts. It uses the registered output to carry a result computed in one context into a later one. Loading the table is a slow, separate step. While a configuration-mode input is high, evaluation pauses, the context counter holds, and single bits can be written by entry, context and value. Moving from one context to the next never needs any rewriting.

Top module: `fold_lut`

## Requirements
- R1: A synchronous reset, while high, forces `fold_idx` to 0, `lut_q` to 0 and `user_strb` to 0, and clears every table bit, so `lut_y` reads 0 for every address in every context after reset.
- R2: While `cfg_mode` is 0, `fold_idx` increases by one on each clock edge and goes from 7 back to 0.
- R3: While `cfg_mode` is 1, `fold_idx` keeps its value.
- R4: `user_strb` is 1 for exactly one cycle, the cycle in which `fold_idx` has just wrapped from 7 to 0. In every other cycle it is 0, including while the counter is held at 0 in configuration mode.
- R5: `lut_y` is combinational and equals the table bit at entry `lut_in` in context `fold_idx`. It follows `lut_in` changes made in the same cycle that the context advances.
- R6: `lut_q` equals the value `lut_y` had in the previous cycle, so a result is held for one full fast cycle into the next context.
- R7: With `cfg_mode`=1 and `cfg_we`=1, the clock edge stores `cfg_bit` at entry `cfg_ent` in context `cfg_fold`, and every other bit keeps its value.
- R8: A write request with `cfg_mode`=0 is ignored and leaves every table bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 1 | Pauses evaluation and enables table writes |
| cfg_we | input | 1 | Write request for one table bit |
| cfg_ent | input | 4 | Entry to write |
| cfg_fold | input | 3 | Context to write |
| cfg_bit | input | 1 | Value to write |
| lut_in | input | 4 | Logic input that addresses the table |
| lut_y | output | 1 | Combinational result for the current context |
| lut_q | output | 1 | Result of the previous fast cycle |
| fold_idx | output | 3 | Current context |
| user_strb | output | 1 | Start of a user cycle |

## Verification
The assertions expect reset to be high at the first clock edge, and they expect `lut_in` to be driven to known values from that point on. Without that, the one-cycle hold check on `lut_q` would compare unknown values. The bench holds reset for several edges before it releases it. It changes `lut_in`, `cfg_mode` and the write port only just after a rising edge, so every input is stable long before the next edge samples it. Random table contents and random addresses cover every context, including several wraps from 7 to 0 and switches into and out of configuration mode.

// File: rtl/fold_lut_pkg.sv
package fold_lut_pkg;
   localparam int unsigned DEF_IN_BITS = 4;
   localparam int unsigned DEF_FOLDS   = 8;

   function automatic int unsigned fold_bits(input int unsigned folds);
      return (folds < 2) ? 1 : $clog2(folds);
   endfunction
endpackage

// File: rtl/fold_seq.sv
module fold_seq
   import fold_lut_pkg::*;
#(
   parameter int unsigned N_FOLD = DEF_FOLDS,
   localparam int unsigned FW = fold_bits(N_FOLD)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hold,
   output logic [FW-1:0] fold,
   output logic          strb
);
   localparam logic [FW-1:0] LAST = FW'(N_FOLD - 1);

   always_ff @(posedge clk) begin
      if (rst) begin
         fold <= '0;
         strb <= 1'b0;
      end else begin
         strb <= !hold && (fold == LAST);
         if (!hold) begin
            fold <= (fold == LAST) ? '0 : fold + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ctx_store.sv
module ctx_store
   import fold_lut_pkg::*;
#(
   parameter int unsigned N_IN   = DEF_IN_BITS,
   parameter int unsigned N_FOLD = DEF_FOLDS,
   localparam int unsigned FW    = fold_bits(N_FOLD),
   localparam int unsigned N_ENT = 1 << N_IN
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      wr_en,
   input  logic [N_IN-1:0]           wr_ent,
   input  logic [FW-1:0]             wr_fold,
   input  logic                      wr_bit,
   output logic [N_ENT*N_FOLD-1:0]   bits
);
   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      for (genvar f = 0; f < N_FOLD; f++) begin : g_fold
         logic hit;
         assign hit = wr_en && (wr_ent == N_IN'(e)) && (wr_fold == FW'(f));
         always_ff @(posedge clk) begin
            if (rst) begin
               bits[e*N_FOLD + f] <= 1'b0;
            end else if (hit) begin
               bits[e*N_FOLD + f] <= wr_bit;
            end
         end
      end
   end
endmodule

// File: rtl/fold_pick.sv
module fold_pick
   import fold_lut_pkg::*;
#(
   parameter int unsigned N_IN       = DEF_IN_BITS,
   parameter int unsigned N_FOLD     = DEF_FOLDS,
   parameter bit          FOLD_FIRST = 1'b1,
   localparam int unsigned FW        = fold_bits(N_FOLD),
   localparam int unsigned N_ENT     = 1 << N_IN
) (
   input  logic [N_ENT*N_FOLD-1:0] bits,
   input  logic [N_IN-1:0]         addr,
   input  logic [FW-1:0]           fold,
   output logic                    y
);
   if (FOLD_FIRST) begin : g_fold_first
      // context select is shared by all entries, then the address picks one
      logic [N_ENT-1:0] plane;
      for (genvar e = 0; e < N_ENT; e++) begin : g_plane
         logic [N_FOLD-1:0] word;
         assign word     = bits[e*N_FOLD +: N_FOLD];
         assign plane[e] = word[fold];
      end
      assign y = plane[addr];
   end else begin : g_addr_first
      // address picks an entry word, then the context picks a bit
      logic [N_FOLD-1:0] word;
      always_comb begin
         word = '0;
         for (int e = 0; e < N_ENT; e++) begin
            if (addr == N_IN'(e)) word = bits[e*N_FOLD +: N_FOLD];
         end
      end
      assign y = word[fold];
   end
endmodule

// File: rtl/fold_lut.sv
module fold_lut
   import fold_lut_pkg::*;
#(
   parameter int unsigned N_IN       = DEF_IN_BITS,
   parameter int unsigned N_FOLD     = DEF_FOLDS,
   parameter bit          FOLD_FIRST = 1'b1,
   localparam int unsigned FW        = fold_bits(N_FOLD),
   localparam int unsigned N_ENT     = 1 << N_IN
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cfg_mode,
   input  logic            cfg_we,
   input  logic [N_IN-1:0] cfg_ent,
   input  logic [FW-1:0]   cfg_fold,
   input  logic            cfg_bit,
   input  logic [N_IN-1:0] lut_in,
   output logic            lut_y,
   output logic            lut_q,
   output logic [FW-1:0]   fold_idx,
   output logic            user_strb
);
   if (N_IN < 1 || N_IN > 8) begin : g_bad_in
      $error("fold_lut: N_IN must be 1..8");
   end
   if (N_FOLD < 2 || N_FOLD > 64) begin : g_bad_fold
      $error("fold_lut: N_FOLD must be 2..64");
   end

   logic [N_ENT*N_FOLD-1:0] store_bits;
   logic                    wr_en;

   assign wr_en = cfg_mode & cfg_we;

   fold_seq #(.N_FOLD(N_FOLD)) u_seq (
      .clk  (clk),
      .rst  (rst),
      .hold (cfg_mode),
      .fold (fold_idx),
      .strb (user_strb)
   );

   ctx_store #(.N_IN(N_IN), .N_FOLD(N_FOLD)) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_ent  (cfg_ent),
      .wr_fold (cfg_fold),
      .wr_bit  (cfg_bit),
      .bits    (store_bits)
   );

   fold_pick #(.N_IN(N_IN), .N_FOLD(N_FOLD), .FOLD_FIRST(FOLD_FIRST)) u_pick (
      .bits (store_bits),
      .addr (lut_in),
      .fold (fold_idx),
      .y    (lut_y)
   );

   always_ff @(posedge clk) begin
      if (rst) lut_q <= 1'b0;
      else     lut_q <= lut_y;
   end
endmodule

// File: rtl/fold_lut_chk.sv
module fold_lut_chk
   import fold_lut_pkg::*;
#(
   parameter int unsigned N_FOLD = DEF_FOLDS,
   localparam int unsigned FW    = fold_bits(N_FOLD)
) (
   input logic          clk,
   input logic          rst,
   input logic          cfg_mode,
   input logic [FW-1:0] fold_idx,
   input logic          user_strb,
   input logic          lut_y,
   input logic          lut_q
);
   localparam logic [FW-1:0] LAST = FW'(N_FOLD - 1);

   // R2
   fold_step_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg_mode |=> fold_idx == (($past(fold_idx) == LAST) ? '0 : $past(fold_idx) + 1'b1));

   // R3
   fold_hold_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_mode |=> $stable(fold_idx));

   // R4
   strb_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
      user_strb |-> fold_idx == '0);

   // R4
   strb_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (!cfg_mode && fold_idx == LAST) |=> user_strb);

   // R4
   strb_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !(!cfg_mode && fold_idx == LAST) |=> !user_strb);

   // R6
   q_hold_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> lut_q == $past(lut_y));
endmodule

bind fold_lut fold_lut_chk #(.N_FOLD(N_FOLD)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cfg_mode  (cfg_mode),
   .fold_idx  (fold_idx),
   .user_strb (user_strb),
   .lut_y     (lut_y),
   .lut_q     (lut_q)
);

// File: tb/sim_fold_lut.sv
`timescale 1ns/100ps
module sim_fold_lut;
   logic       clk = 1'b0;
   logic       rst;
   logic       cfg_mode, cfg_we, cfg_bit;
   logic [3:0] cfg_ent, lut_in;
   logic [2:0] cfg_fold;
   logic       lut_y, lut_q, user_strb;
   logic [2:0] fold_idx;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // behavioural model
   bit [7:0]   mtab [16];
   logic [2:0] mfold;
   logic       mq, mstrb;

   always #2.5 clk = ~clk;

   fold_lut u0 (
      .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
      .cfg_ent(cfg_ent), .cfg_fold(cfg_fold), .cfg_bit(cfg_bit),
      .lut_in(lut_in), .lut_y(lut_y), .lut_q(lut_q),
      .fold_idx(fold_idx), .user_strb(user_strb)
   );

   task automatic cmp(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // advance the model with the inputs now applied, then take one clock edge
   task automatic tick();
      logic yv;
      yv = mtab[lut_in][mfold];
      if (rst) begin
         mfold = '0; mq = 1'b0; mstrb = 1'b0;
         for (int e = 0; e < 16; e++) mtab[e] = '0;
      end else begin
         mq    = yv;
         mstrb = !cfg_mode && (mfold == 3'd7);
         if (cfg_mode && cfg_we) mtab[cfg_ent][cfg_fold] = cfg_bit;
         if (!cfg_mode) mfold = mfold + 3'd1;
      end
      @(posedge clk);
      #1;
   endtask

   task automatic check_all(input string ytag);
      #1;
      cmp(8'(lut_y), 8'(mtab[lut_in][mfold]), ytag);
      cmp(8'(lut_q), 8'(mq), "R6 lut_q");
      cmp(8'(fold_idx), 8'(mfold), cfg_mode ? "R3 fold_idx" : "R2 fold_idx");
      cmp(8'(user_strb), 8'(mstrb), "R4 user_strb");
   endtask

   task automatic t_reset();
      rst = 1'b1; cfg_mode = 1'b0; cfg_we = 1'b0;
      repeat (3) tick();
      cmp(8'(fold_idx), 8'd0, "R1 fold_idx");
      cmp(8'(lut_q), 8'd0, "R1 lut_q");
      cmp(8'(user_strb), 8'd0, "R1 user_strb");
      for (int a = 0; a < 16; a++) begin
         lut_in = 4'(a);
         #0.1;
         cmp(8'(lut_y), 8'd0, "R1 lut_y cleared");
      end
      rst = 1'b0;
      for (int i = 0; i < 9; i++) begin
         tick();
         lut_in = 4'($urandom);
         check_all("R1 lut_y cleared");
      end
   endtask

   task automatic t_load();
      cfg_mode = 1'b1;
      tick();
      for (int e = 0; e < 16; e++) begin
         for (int f = 0; f < 8; f++) begin
            cfg_we = 1'b1; cfg_ent = 4'(e); cfg_fold = 3'(f); cfg_bit = 1'($urandom);
            lut_in = 4'($urandom);
            tick();
            check_all("R7 lut_y after load");
         end
      end
      cfg_we = 1'b0;
   endtask

   task automatic t_eval(input int n);
      cfg_mode = 1'b0;
      for (int i = 0; i < n; i++) begin
         tick();
         lut_in = 4'($urandom);
         check_all("R5 lut_y");
      end
   endtask

   task automatic t_sweep(input string tag);
      cfg_mode = 1'b0; cfg_we = 1'b0;
      for (int a = 0; a < 16; a++) begin
         for (int f = 0; f < 8; f++) begin
            tick();
            lut_in = 4'(a);
            check_all(tag);
         end
      end
   endtask

   task automatic t_ignored_write();
      cfg_mode = 1'b0;
      for (int i = 0; i < 24; i++) begin
         cfg_we = 1'b1; cfg_ent = 4'($urandom); cfg_fold = 3'($urandom);
         cfg_bit = ~mtab[cfg_ent][cfg_fold];
         tick();
         lut_in = cfg_ent;
         check_all("R8 lut_y");
      end
      cfg_we = 1'b0;
      t_sweep("R8 table unchanged");
   endtask

   task automatic t_single_write();
      cfg_mode = 1'b1;
      tick();
      cfg_we = 1'b1; cfg_ent = 4'd9; cfg_fold = 3'd5; cfg_bit = ~mtab[9][5];
      tick();
      cfg_we = 1'b0;
      lut_in = 4'd9;
      check_all("R7 single bit");
      t_sweep("R7 other bits kept");
   endtask

   initial begin
      rst = 1'b1; cfg_mode = 1'b0; cfg_we = 1'b0; cfg_ent = '0;
      cfg_fold = '0; cfg_bit = 1'b0; lut_in = '0;
      mfold = '0; mq = 1'b0; mstrb = 1'b0;
      t_reset();
      t_load();
      t_eval(40);
      t_ignored_write();
      t_single_write();
      t_eval(20);
      t_reset();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule